// File: doc/BRIEF.md
# Oversampling ADC result accumulator

This block adds up a programmable batch of 12-bit conversion results into a 20-bit total. Software selects the batch size and a dither-enable bit through a single control write. While a batch is being summed, the visible total keeps the result of the previous batch. When the last sample of a batch arrives, the new total is loaded and a sticky completion flag is raised. Because a new total appears once per batch, the output rate is the conversion rate divided by the batch size.

The sequencing is held by a two-state machine. `ST_IDLE` means the running sum and the sample counter are both zero and no sample of the current batch has been taken. `ST_ACCUM` means a partial sum is held.

The transitions are:
- *take-first*: `ST_IDLE` to `ST_ACCUM`, on a valid sample that does not end the batch.
- *take-more*: `ST_ACCUM` to `ST_ACCUM`, on a valid sample that does not end the batch.
- *finish*: any state to `ST_IDLE`, on the valid sample that ends the batch. The total is loaded here.
- *restart*: any state to `ST_IDLE`, on a control write.

A batch size of one always takes *finish*, so each sample passes straight through. The dither bit is only stored and driven out to the analog side.

Top module: `adc_oversum`

## Requirements
- R1: After reset the total is 0x00000, the completion flag is 0, the dither output is 0 and the count-code readback is 000.
- R2: A control write loads the dither bit and the count code. It sets the total to 0x00000 on the next clock edge and restarts the batch from an empty sum.
- R3: While a batch is incomplete and no control write occurs, the total keeps its value.
- R4: On the clock edge that loads a batch result into the total, the completion flag becomes 1.
- R5: With count code 000, each valid sample appears on the next edge in total[11:0], with total[19:12] zero.
- R6: Count codes 000 to 110 select batch sizes of 2 to the power of the code (1 to 64), and code 111 selects 256.
- R7: The total never exceeds 0xFFFFF. A batch sum above that limit is stored as 0xFFFFF. A full 256-sample batch of 0xFFF gives 0xFFF00.
- R8: The dither output follows the dither bit of the last control write and has no effect on the totals.
- R9: After a batch completes, the next valid sample starts the following batch, so back-to-back samples are never dropped.
- R10: The completion flag stays 1 until a `done_clr` pulse. If a clear and a completion coincide, the flag ends at 1.
- R11: A valid sample that arrives in the same cycle as a control write is discarded. The new batch starts with the next valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_dither | input | 1 | Dither-enable bit to store |
| cfg_code | input | 3 | Batch-size code to store |
| sample_valid | input | 1 | Conversion result strobe |
| sample_data | input | 12 | Conversion result |
| done_clr | input | 1 | Clears the completion flag |
| dither_en | output | 1 | Stored dither-enable bit |
| count_code | output | 3 | Stored batch-size code |
| total | output | 20 | Read-only batch total |
| done_flag | output | 1 | Sticky batch-completion flag |

## Verification
The assertions take for granted that `sample_valid`, `cfg_wr` and `done_clr` are single-cycle qualifiers sampled at the rising edge. They also assume that `sample_data` is meaningful only while `sample_valid` is high; nothing else about input timing is required. The stimulus changes every input just after the falling edge, so every strobe is stable across exactly one rising edge. The stimulus also places control writes both between batches and mid-batch, and in the same cycle as a valid sample, and places a clear on the same edge as a completion, so the collision rules are exercised.

// File: rtl/adc_oversum_pkg.sv
package adc_oversum_pkg;

    localparam int CODE_W    = 3;
    localparam int BATCH_MAX = 256;
    localparam int CNT_W     = $clog2(BATCH_MAX + 1);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } acc_state_e;

    // Batch size: powers of two for the lower codes, the largest batch for the top code.
    function automatic logic [CNT_W-1:0] batch_size(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] sz;
        if (code == {CODE_W{1'b1}})
            sz = CNT_W'(BATCH_MAX);
        else
            sz = CNT_W'(1) << code;
        return sz;
    endfunction

endpackage

// File: rtl/adc_oversum_cfg.sv
module adc_oversum_cfg
    import adc_oversum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_dither,
    input  logic [CODE_W-1:0] cfg_code,
    output logic              dither_q,
    output logic [CODE_W-1:0] code_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dither_q <= 1'b0;
            code_q   <= '0;
        end else if (cfg_wr) begin
            dither_q <= cfg_dither;
            code_q   <= cfg_code;
        end
    end

    // R8: the stored dither bit reflects the last write.
    p_dither_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (dither_q == $past(cfg_dither)) && (code_q == $past(cfg_code)));

    // R8: without a write the stored bits hold.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(dither_q) && $stable(code_q));

endmodule

// File: rtl/adc_oversum_core.sv
module adc_oversum_core
    import adc_oversum_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TOTAL_W  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CODE_W-1:0]   code_q,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic                done_clr,
    output logic [TOTAL_W-1:0]  total_q,
    output logic                flag_q
);

    localparam logic [TOTAL_W-1:0] TOTAL_MAX = {TOTAL_W{1'b1}};
    localparam int                 PAD_W     = TOTAL_W + 1 - SAMPLE_W;

    acc_state_e         state_q, state_nx;
    logic [TOTAL_W-1:0] acc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [TOTAL_W-1:0] base;
    logic [TOTAL_W:0]   ext_sum;
    logic [TOTAL_W-1:0] sat_sum;
    logic               take;
    logic               last;
    logic               batch_done;

    // A sample is taken only if no control write arrives with it.
    assign take       = sample_valid && !cfg_wr;
    assign last       = (cnt_q + CNT_W'(1)) == batch_size(code_q);
    assign batch_done = take && last;

    assign base    = (state_q == ST_IDLE) ? '0 : acc_q;
    assign ext_sum = {1'b0, base} + {{PAD_W{1'b0}}, sample_data};
    assign sat_sum = ext_sum[TOTAL_W] ? TOTAL_MAX : ext_sum[TOTAL_W-1:0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Transitions: take-first, take-more, finish, restart
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cfg_wr)          state_nx = ST_IDLE;
                else if (batch_done) state_nx = ST_IDLE;
                else if (take)       state_nx = ST_ACCUM;
            end
            ST_ACCUM: begin
                if (cfg_wr)          state_nx = ST_IDLE;
                else if (batch_done) state_nx = ST_IDLE;
            end
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            total_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (cfg_wr) begin
                acc_q   <= '0;
                cnt_q   <= '0;
                total_q <= '0;
            end else if (batch_done) begin
                acc_q   <= '0;
                cnt_q   <= '0;
                total_q <= sat_sum;
            end else if (take) begin
                acc_q   <= sat_sum;
                cnt_q   <= cnt_q + CNT_W'(1);
            end
            if (batch_done)    flag_q <= 1'b1;
            else if (done_clr) flag_q <= 1'b0;
        end
    end

    // R2: a control write empties the total.
    p_write_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> total_q == '0);

    // R3: the total holds while a batch is incomplete.
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr && !batch_done) |=> $stable(total_q));

    // R4: a batch result raises the flag on the same edge.
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        batch_done |=> flag_q);

    // R5: code 000 passes the sample into the low bits.
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0 && take) |=> total_q == TOTAL_W'($past(sample_data)));

    // R7: a sum past the limit is clamped.
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (batch_done && ext_sum[TOTAL_W]) |=> total_q == TOTAL_MAX);

    // R9: ST_IDLE means nothing of the current batch is held.
    p_idle_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> cnt_q == '0);

    // R10: only a clear without a completion drops the flag.
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !done_clr) |=> flag_q);

endmodule

// File: rtl/adc_oversum.sv
module adc_oversum
    import adc_oversum_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TOTAL_W  = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_dither,
    input  logic [CODE_W-1:0]   cfg_code,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    input  logic                done_clr,
    output logic                dither_en,
    output logic [CODE_W-1:0]   count_code,
    output logic [TOTAL_W-1:0]  total,
    output logic                done_flag
);

    logic [CODE_W-1:0] code_q;

    adc_oversum_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_dither (cfg_dither),
        .cfg_code   (cfg_code),
        .dither_q   (dither_en),
        .code_q     (code_q)
    );

    adc_oversum_core #(
        .SAMPLE_W (SAMPLE_W),
        .TOTAL_W  (TOTAL_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .code_q       (code_q),
        .sample_valid (sample_valid),
        .sample_data  (sample_data),
        .done_clr     (done_clr),
        .total_q      (total),
        .flag_q       (done_flag)
    );

    assign count_code = code_q;

endmodule

// File: tb/adc_oversum_bench.sv
module adc_oversum_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int LIMIT      = 20'hFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_dither = 1'b0;
    logic [2:0]  cfg_code = 3'd0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_data = 12'd0;
    logic        done_clr = 1'b0;
    logic        dither_en;
    logic [2:0]  count_code;
    logic [19:0] total;
    logic        done_flag;

    int total_checks = 0;
    int bad_checks   = 0;
    int cyc          = 0;

    // Behavioural reference state
    int m_dither = 0, m_code = 0, m_sum = 0, m_n = 0, m_total = 0, m_flag = 0;

    adc_oversum u_adc_oversum (
        .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_dither (cfg_dither),
        .cfg_code (cfg_code), .sample_valid (sample_valid), .sample_data (sample_data),
        .done_clr (done_clr), .dither_en (dither_en), .count_code (count_code),
        .total (total), .done_flag (done_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int size_of(input int code);
        int sz;
        if (code == 7) sz = 256;
        else begin
            sz = 1;
            for (int k = 0; k < code; k++) sz = sz * 2;
        end
        return sz;
    endfunction

    always @(posedge clk) begin
        int s;
        int fin;
        if (!rst_n) begin
            m_dither = 0; m_code = 0; m_sum = 0; m_n = 0; m_total = 0; m_flag = 0;
        end else begin
            fin = 0;
            if (cfg_wr) begin
                m_dither = int'(cfg_dither); m_code = int'(cfg_code);
                m_sum = 0; m_n = 0; m_total = 0;
            end else if (sample_valid) begin
                s = m_sum + int'(sample_data);
                if (s > LIMIT) s = LIMIT;
                m_n = m_n + 1;
                if (m_n == size_of(m_code)) begin
                    m_total = s; m_sum = 0; m_n = 0; fin = 1;
                end else m_sum = s;
            end
            if (fin != 0) m_flag = 1;
            else if (done_clr) m_flag = 0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total_checks++;
        if (act != exp) begin
            bad_checks++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        check("R3 total vs model", int'(total), m_total);
        check("R4 flag vs model", int'(done_flag), m_flag);
        check("R8 dither vs model", int'(dither_en), m_dither);
        check("R2 code vs model", int'(count_code), m_code);
    endtask

    // One cycle: compare at the falling edge, then drive the next inputs.
    task automatic cyc1(input logic wr, input logic dth, input logic [2:0] code,
                        input logic vld, input logic [11:0] data, input logic clr);
        @(negedge clk);
        compare_model();
        cfg_wr = wr; cfg_dither = dth; cfg_code = code;
        sample_valid = vld; sample_data = data; done_clr = clr;
    endtask

    task automatic wr_cfg(input logic dth, input logic [2:0] code);
        cyc1(1'b1, dth, code, 1'b0, 12'd0, 1'b0);
    endtask

    task automatic smp(input logic [11:0] d);
        cyc1(1'b0, 1'b0, 3'd0, 1'b1, d, 1'b0);
    endtask

    task automatic idle();
        cyc1(1'b0, 1'b0, 3'd0, 1'b0, 12'd0, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            bad_checks++;
            total_checks++;
            $display("FAIL watchdog all requirements actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        idle(); idle();
        // R1: reset values
        check("R1 total", int'(total), 0);
        check("R1 flag", int'(done_flag), 0);
        check("R1 dither", int'(dither_en), 0);
        check("R1 code", int'(count_code), 0);
        rst_n = 1'b1;
        idle();

        // R5: pass-through with code 000
        smp(12'hABC); idle();
        check("R5 passthrough", int'(total), 'hABC);
        check("R4 flag on load", int'(done_flag), 1);
        smp(12'hFFF); idle();
        check("R5 passthrough high", int'(total), 'hFFF);

        // R2/R8: write clears total, stores dither
        wr_cfg(1'b1, 3'd2); idle();
        check("R2 write clears", int'(total), 0);
        check("R8 dither stored", int'(dither_en), 1);
        cyc1(1'b0, 1'b0, 3'd0, 1'b0, 12'd0, 1'b1); idle();
        smp(12'd100); smp(12'd200); smp(12'd300); idle();
        check("R3 hold mid-batch", int'(total), 0);
        check("R10 flag cleared", int'(done_flag), 0);
        smp(12'd400); idle();
        check("R4 batch of four", int'(total), 1000);
        check("R4 flag set", int'(done_flag), 1);
        idle();
        check("R10 flag sticky", int'(done_flag), 1);

        // R9: back-to-back batches
        smp(12'd1); smp(12'd2); smp(12'd3); smp(12'd4);
        smp(12'd10); smp(12'd20); smp(12'd30); smp(12'd40); idle();
        check("R9 second batch", int'(total), 100);

        // R2: mid-batch write restarts
        smp(12'd7); smp(12'd7);
        wr_cfg(1'b0, 3'd2);
        smp(12'd5); smp(12'd5); smp(12'd5); smp(12'd5); idle();
        check("R2 restart from empty", int'(total), 20);
        check("R8 dither low", int'(dither_en), 0);

        // R11: write with a valid sample discards it
        cyc1(1'b1, 1'b0, 3'd1, 1'b1, 12'd999, 1'b0);
        smp(12'd5); smp(12'd6); idle();
        check("R11 sample discarded", int'(total), 11);

        // R10: clear and completion together
        smp(12'd1);
        cyc1(1'b0, 1'b0, 3'd0, 1'b1, 12'd2, 1'b1); idle();
        check("R10 completion wins", int'(done_flag), 1);
        check("R10 total", int'(total), 3);

        // R6: every code selects its batch size
        for (int c = 0; c < 8; c++) begin
            wr_cfg(c[0], 3'(c));
            for (int i = 0; i < size_of(c); i++) smp(12'd1);
            idle();
            check("R6 batch size", int'(total), size_of(c));
        end

        // R7: largest batch of full-scale samples
        wr_cfg(1'b1, 3'd7);
        for (int i = 0; i < 256; i++) smp(12'hFFF);
        idle();
        check("R7 full-scale sum", int'(total), 'hFFF00);
        idle(); idle();

        $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule